// File: doc/BRIEF.md
# Chip-Select Framed Dual-Channel Serial Readout with Power-State Control

This block is the digital serial side of a dual simultaneous-sampling 14-bit converter. The host pulls chip-select low to open a frame, and both channel samples are latched at that moment. The host then toggles a serial clock. The block counts the falling edges of that clock and shifts the results out on two data lines. Each line first carries its own channel and then, if chip-select is still low, the other channel. Both lines release on the 32nd falling edge, or earlier if chip-select rises first.

The point in the frame at which chip-select rises also sets the power state. A very early rise is taken as a glitch and changes nothing. A rise in the middle window powers the device down, and a second such abort while already powered down escalates to full power-down. A frame that runs long enough wakes the device. That wake-up frame returns zeros, and valid data comes from the frame after it. The three-state pins are modelled as data outputs plus a shared drive enable. Both inputs are oversampled on a fast system clock.

Top module: `adc_frame_if`

## Requirements
- R1: After reset, pwrState is 0 (normal), sdoEn is 0 and both data outputs are 0.
- R2: Whenever csN is high, sdoEn is 0 and both data outputs are 0. This also holds in the cycles right after a rise that ends a frame.
- R3: Bit n of a frame is the bit shown after n serial-clock falling edges, with bit 0 shown once csN falls. Bits 0-1 are zero and bits 2-15 are the 14-bit result, MSB first. Line A carries channel A and line B carries channel B.
- R4: Bits 16-31 repeat the same format for the other channel: line A carries channel B and line B carries channel A. Bits 16-17 are therefore the two trailing zeros after the first word.
- R5: From the 32nd falling edge onward, sdoEn is 0 even while csN stays low.
- R6: If csN rises after fewer than 2 falling edges, pwrState does not change.
- R7: If csN rises after 2 to 9 falling edges while pwrState is 0, pwrState becomes 1 (partial power-down).
- R8: If csN rises after 2 to 9 falling edges while pwrState is 1 or 2, pwrState becomes 2 (full power-down).
- R9: If csN rises after 10 or more falling edges, pwrState becomes 0 from any state.
- R10: A frame that opens while pwrState is not 0 drives zeros on both lines for every bit. The next frame opened in state 0 carries valid data.
- R11: The channel samples are latched when csN falls. Changes on sampleA and sampleB during the frame do not alter the shifted data.
- R12: pwrState never moves directly from 0 to 2 or from 2 to 1, and it changes only in the cycle after a csN rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip-select, active low |
| sclk | input | 1 | Serial clock, idles high; falling edges are counted |
| sampleA | input | 14 | Channel A conversion word from the sampler |
| sampleB | input | 14 | Channel B conversion word from the sampler |
| sdoA | output | 1 | Serial data for line A |
| sdoB | output | 1 | Serial data for line B |
| sdoEn | output | 1 | Drive enable shared by both data lines (0 = high impedance) |
| pwrState | output | 2 | 0 normal, 1 partial power-down, 2 full power-down |

## Verification
The properties assume that csN and sclk are already synchronous to clk. They also assume each input level lasts at least one clk cycle, and that a csN rise never lands in the same cycle as an sclk fall. The stimulus meets these conditions by changing csN and sclk only on the falling edge of clk. Each serial-clock phase is held for two clk cycles, and sclk is returned high before chip-select moves. Under these conditions the edge count at a chip-select rise is exact. That is what lets the power-state transitions be predicted for every abort point from 0 to 33 edges, in each of the three starting states.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

  typedef enum logic [1:0] {
    PWR_NORMAL  = 2'd0,
    PWR_PARTIAL = 2'd1,
    PWR_FULL    = 2'd2
  } pwr_e;

  // Strobes from the frame control to the shift datapath
  typedef struct packed {
    logic capture;   // latch both samples this cycle
    logic driveEn;   // data lines are driven
    logic blank;     // wake-up frame: force zeros
  } ctrl_t;

endpackage

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_frame_pkg::*;
#(
  parameter int FRAME_EDGES = 32,
  parameter int PART_EDGE   = 2,
  parameter int AWAKE_EDGE  = 10,
  localparam int CNT_W      = $clog2(FRAME_EDGES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             sclk,
  output ctrl_t            ctl,
  output logic [CNT_W-1:0] bitPos,
  output pwr_e             pwrState
);

  logic             csD, sclkD, active, wakeFrame;
  logic [CNT_W-1:0] edgeCnt;
  pwr_e             pwrQ, pwrNext;
  logic             csFall, csRise, sclkFall;

  assign csFall   = csD & ~csN;
  assign csRise   = ~csD & csN;
  assign sclkFall = sclkD & ~sclk;

  // Power decision from the edge count at which chip-select rises
  always_comb begin
    if (edgeCnt < CNT_W'(PART_EDGE))
      pwrNext = pwrQ;
    else if (edgeCnt < CNT_W'(AWAKE_EDGE))
      pwrNext = (pwrQ == PWR_NORMAL) ? PWR_PARTIAL : PWR_FULL;
    else
      pwrNext = PWR_NORMAL;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csD       <= 1'b1;
      sclkD     <= 1'b1;
      active    <= 1'b0;
      wakeFrame <= 1'b0;
      edgeCnt   <= '0;
      pwrQ      <= PWR_NORMAL;
    end else begin
      csD   <= csN;
      sclkD <= sclk;
      if (csFall) begin
        active    <= 1'b1;
        edgeCnt   <= '0;
        wakeFrame <= (pwrQ != PWR_NORMAL);
      end else if (csRise) begin
        active <= 1'b0;
        if (active) pwrQ <= pwrNext;
      end else if (active && sclkFall && edgeCnt < CNT_W'(FRAME_EDGES)) begin
        edgeCnt <= edgeCnt + 1'b1;
      end
    end
  end

  assign ctl.capture = csFall;
  assign ctl.driveEn = active & ~csN & (edgeCnt < CNT_W'(FRAME_EDGES));
  assign ctl.blank   = wakeFrame;
  assign bitPos      = edgeCnt;
  assign pwrState    = pwrQ;

endmodule

// File: rtl/adc_frame_dp.sv
module adc_frame_dp
  import adc_frame_pkg::*;
#(
  parameter int RES_BITS   = 14,
  parameter int LEAD_ZEROS = 2,
  parameter int CNT_W      = 6,
  localparam int WORD_BITS = RES_BITS + LEAD_ZEROS
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_t               ctl,
  input  logic [CNT_W-1:0]    bitPos,
  input  logic [RES_BITS-1:0] sampleA,
  input  logic [RES_BITS-1:0] sampleB,
  output logic                sdoA,
  output logic                sdoB
);

  logic [RES_BITS-1:0] capWord [2];
  logic [1:0]          laneBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capWord[0] <= '0;
      capWord[1] <= '0;
    end else if (ctl.capture) begin
      capWord[0] <= sampleA;
      capWord[1] <= sampleB;
    end
  end

  // Each lane sends its own channel first, then the other channel
  for (genvar g = 0; g < 2; g++) begin : g_lane
    always_comb begin
      int pos, idx;
      logic [RES_BITS-1:0] word;
      pos = int'(bitPos);
      if (pos >= WORD_BITS) begin
        word = capWord[1-g];
        idx  = pos - WORD_BITS;
      end else begin
        word = capWord[g];
        idx  = pos;
      end
      if (!ctl.driveEn || ctl.blank || idx < LEAD_ZEROS || idx >= WORD_BITS)
        laneBit[g] = 1'b0;
      else
        laneBit[g] = word[WORD_BITS-1-idx];
    end
  end

  assign sdoA = laneBit[0];
  assign sdoB = laneBit[1];

endmodule

// File: rtl/adc_frame_if.sv
module adc_frame_if
  import adc_frame_pkg::*;
#(
  parameter int RES_BITS    = 14,
  parameter int LEAD_ZEROS  = 2,
  parameter int PART_EDGE   = 2,
  parameter int AWAKE_EDGE  = 10,
  localparam int WORD_BITS  = RES_BITS + LEAD_ZEROS,
  localparam int FRAME_EDGES = 2 * WORD_BITS,
  localparam int CNT_W      = $clog2(FRAME_EDGES + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csN,
  input  logic                sclk,
  input  logic [RES_BITS-1:0] sampleA,
  input  logic [RES_BITS-1:0] sampleB,
  output logic                sdoA,
  output logic                sdoB,
  output logic                sdoEn,
  output logic [1:0]          pwrState
);

  ctrl_t            ctl;
  logic [CNT_W-1:0] bitPos;
  pwr_e             pwrQ;

  adc_frame_ctrl #(
    .FRAME_EDGES(FRAME_EDGES),
    .PART_EDGE  (PART_EDGE),
    .AWAKE_EDGE (AWAKE_EDGE)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .csN     (csN),
    .sclk    (sclk),
    .ctl     (ctl),
    .bitPos  (bitPos),
    .pwrState(pwrQ)
  );

  adc_frame_dp #(
    .RES_BITS  (RES_BITS),
    .LEAD_ZEROS(LEAD_ZEROS),
    .CNT_W     (CNT_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .bitPos (bitPos),
    .sampleA(sampleA),
    .sampleB(sampleB),
    .sdoA   (sdoA),
    .sdoB   (sdoB)
  );

  assign sdoEn    = ctl.driveEn;
  assign pwrState = pwrQ;

endmodule

// File: rtl/adc_frame_chk.sv
module adc_frame_chk (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       sdoA,
  input logic       sdoB,
  input logic       sdoEn,
  input logic [1:0] pwrState
);

  // R2: chip-select high releases both lines
  a_r2_release_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (!sdoEn && !sdoA && !sdoB));

  // R2: an undriven line carries no data
  a_r2_quiet_when_undriven: assert property (@(posedge clk) disable iff (!rstN)
    !sdoEn |-> (!sdoA && !sdoB));

  // R12: the power state holds while chip-select stays low
  a_r12_hold_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    !csN |=> $stable(pwrState));

  // R12: the power state holds while chip-select stays high
  a_r12_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN)) |=> $stable(pwrState));

  // R12: no jump from normal straight to full power-down
  a_r12_no_normal_to_full: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd0) |=> (pwrState != 2'd2));

  // R8: full power-down never relaxes to partial
  a_r8_no_full_to_partial: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd2) |=> (pwrState != 2'd1));

  // R12: only the three defined state codes appear
  a_r12_legal_code: assert property (@(posedge clk) disable iff (!rstN)
    pwrState != 2'd3);

endmodule

bind adc_frame_if adc_frame_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .csN     (csN),
  .sdoA    (sdoA),
  .sdoB    (sdoB),
  .sdoEn   (sdoEn),
  .pwrState(pwrState)
);

// File: tb/tb_adc_frame_if.sv
module tb_adc_frame_if;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        sclk = 1'b1;
  logic [13:0] sampleA = '0;
  logic [13:0] sampleB = '0;
  logic        sdoA, sdoB, sdoEn;
  logic [1:0]  pwrState;

  int checks = 0;
  int errors = 0;
  int expPwr = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  adc_frame_if dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk),
    .sampleA(sampleA), .sampleB(sampleB),
    .sdoA(sdoA), .sdoB(sdoB), .sdoEn(sdoEn), .pwrState(pwrState)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int pattern(input int s);
    return (s * 32'h2A5 + 32'h1357) & 32'h3FFF;
  endfunction

  // Expected bit n on a line whose own word is own and other word is oth
  function automatic int expBit(input int n, input logic [13:0] own,
                                input logic [13:0] oth, input bit wake);
    int i;
    logic [13:0] w;
    if (n >= 32 || wake) return 0;
    w = (n < 16) ? own : oth;
    i = n % 16;
    if (i < 2) return 0;
    return int'(w[15 - i]);
  endfunction

  function automatic int nextPwr(input int cur, input int k);
    if (k < 2) return cur;
    if (k < 10) return (cur == 0) ? 1 : 2;
    return 0;
  endfunction

  function automatic string pwrTag(input int cur, input int k);
    if (k < 2) return "R6";
    if (k < 10) return (cur == 0) ? "R7" : "R8";
    return "R9";
  endfunction

  task automatic checkBits(input int n, input logic [13:0] a, input logic [13:0] b,
                           input bit wake, input string tagIn);
    string tag;
    int ea, eb;
    tag = tagIn;
    if (tag == "") tag = wake ? "R10" : (n >= 32 ? "R5" : (n >= 16 ? "R4" : "R3"));
    check(sdoEn == (n < 32), tag, int'(sdoEn), int'(n < 32));
    ea = expBit(n, a, b, wake);
    eb = expBit(n, b, a, wake);
    check(int'(sdoA) == ea, tag, int'(sdoA), ea);
    check(int'(sdoB) == eb, tag, int'(sdoB), eb);
  endtask

  // One frame of 'edges' serial-clock falls; optionally disturbs the samples
  task automatic runFrame(input int edges, input logic [13:0] a, input logic [13:0] b,
                          input bit disturb, input string tag);
    bit wake;
    int nxt;
    wake = (expPwr != 0);
    sampleA = a;
    sampleB = b;
    tick(1);
    csN = 1'b0;
    tick(2);
    checkBits(0, a, b, wake, tag);
    for (int e = 1; e <= edges; e++) begin
      sclk = 1'b0;
      tick(2);
      sclk = 1'b1;
      if (disturb) begin
        sampleA = ~a;
        sampleB = a ^ b;
      end
      tick(2);
      checkBits(e, a, b, wake, tag);
    end
    csN = 1'b1;
    tick(2);
    check(!sdoEn && !sdoA && !sdoB, "R2", int'(sdoEn), 0);
    nxt = nextPwr(expPwr, edges);
    check(int'(pwrState) == nxt, pwrTag(expPwr, edges), int'(pwrState), nxt);
    expPwr = nxt;
    tick(2);
  endtask

  task automatic gotoState(input int s);
    runFrame(16, 14'h1234, 14'h0ABC, 1'b0, "");
    if (s >= 1) runFrame(5, 14'h0F0F, 14'h30C3, 1'b0, "");
    if (s >= 2) runFrame(5, 14'h2222, 14'h1111, 1'b0, "");
  endtask

  initial begin
    tick(3);
    // R1: reset state
    check(pwrState == 2'd0, "R1", int'(pwrState), 0);
    check(!sdoEn && !sdoA && !sdoB, "R1", int'(sdoEn), 0);
    rstN = 1'b1;
    tick(3);
    check(pwrState == 2'd0, "R1", int'(pwrState), 0);

    // R3, R4, R5: full frames with assorted words, including extremes
    runFrame(32, 14'h0000, 14'h3FFF, 1'b0, "");
    runFrame(32, 14'h3FFF, 14'h0000, 1'b0, "");
    runFrame(32, 14'h2AAA, 14'h1555, 1'b0, "");
    for (int s = 0; s < 6; s++)
      runFrame(33, 14'(pattern(s)), 14'(pattern(s + 40)), 1'b0, "");

    // R11: sample inputs change mid-frame, data must not follow
    runFrame(32, 14'h2D4B, 14'h12B4, 1'b1, "R11");

    // R6..R9: every abort point from every starting state
    for (int st = 0; st < 3; st++) begin
      for (int k = 0; k <= 33; k++) begin
        gotoState(st);
        runFrame(k, 14'(pattern(k)), 14'(pattern(k + 7)), 1'b0, "");
      end
    end

    // R10: wake-up frame from partial gives zeros, next frame valid
    gotoState(1);
    runFrame(20, 14'h3A5C, 14'h05A3, 1'b0, "R10");
    check(pwrState == 2'd0, "R10", int'(pwrState), 0);
    runFrame(32, 14'h3A5C, 14'h05A3, 1'b0, "R10");

    // R8: abort in window from full stays full
    gotoState(2);
    runFrame(9, 14'h0001, 14'h2000, 1'b0, "");
    check(pwrState == 2'd2, "R8", int'(pwrState), 2);
    runFrame(12, 14'h0001, 14'h2000, 1'b0, "R10");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule